// File: doc/BRIEF.md
# Serial Port Interrupt Prioritizer

This block is the interrupt logic of a 16550-style serial port. Other parts of the port raise five event flags: a receive line error (overrun, parity, framing or break), received data available, a character time-out, transmit holding register empty, and a modem status change. Each flag pulse sets a sticky pending bit. A 4-bit enable register masks the bits. A fixed-priority encoder picks the most urgent enabled pending source. The block shows that source as an identification byte and drives one active-high interrupt request. Software finds out which line error occurred by reading the line status register, which sits outside this block.

The host reaches the block through a register strobe interface: an address, a read strobe and a write strobe. A two-state machine controls the identification snapshot. In `ST_IDLE` the snapshot follows the live encoder output, one clock behind it. The transition *capture* is taken when an identification read starts. It moves to `ST_FROZEN`, which holds the snapshot, and with it the interrupt request, for as long as the read strobe stays on that address. The transition *release* is taken when the read ends and returns to `ST_IDLE`. On release, the transmit-empty source is acknowledged if the frozen value reported it. Other sources are cleared by reads of the receive buffer, line status or modem status offsets. A write to the transmit holding offset also clears the transmit-empty source.

Top module: `uirq_ctrl`

## Requirements
- R1: After reset the enable register reads 0x00, no source is pending, the identification byte at offset 2 reads 0x01 with FIFO mode off, and `irq` is low.
- R2: A write to offset 1 stores data bits 3:0 in the enable register: bit 0 enables data available and time-out, bit 1 transmit empty, bit 2 line error, bit 3 modem change. Bits 7:4 always read 0 at offset 1.
- R3: Identification bits 3:0 read 0110 for line error, 0100 for data available, 1100 for time-out, 0010 for transmit empty, 0000 for modem change and 0001 for none pending. `irq` is the inverse of bit 0.
- R4: When several enabled sources are pending, the reported one follows this order: line error, then data available, then time-out, then transmit empty, then modem change.
- R5: A pending source whose enable bit is 0 is not reported. It stays pending and is reported once its enable bit is set.
- R6: The time-out event is ignored while `fifo_mode` is 0. In FIFO mode it reports 1100, and data available is reported ahead of it.
- R7: Identification bits 7:6 both equal `fifo_mode`, and bits 5:4 read 0.
- R8: While the read strobe stays on offset 2, the identification byte and `irq` keep the value shown in the first cycle of the read, even if new events arrive.
- R9: Transmit empty is cleared when an identification read that reported 0010 ends, or by a write to offset 0. An identification read that reported another source leaves it pending.
- R10: A read at offset 5 clears the line error source, and a read at offset 6 clears the modem change source.
- R11: A read at offset 0 clears both the data available and the time-out sources.
- R12: An event pulse sampled at clock edge k is visible in the identification byte and `irq` after edge k+1 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_rd | input | 1 | Read strobe, held for the whole access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for offsets 1 and 2, else 0 |
| fifo_mode | input | 1 | FIFO control bit 0 |
| ev_line_err | input | 1 | Receive line error event |
| ev_rx_avail | input | 1 | Received data available event |
| ev_rx_timeout | input | 1 | Character time-out event |
| ev_tx_empty | input | 1 | Transmit holding register empty event |
| ev_modem_chg | input | 1 | Modem status change event |
| irq | output | 1 | Interrupt request, active high |

## Verification
A wrong pending bit or a wrong enable bit shows up as a wrong identification code or a wrong `irq` level. This happens two clock edges after the event or the register write that caused it, so each check samples after that delay. A wrong machine state shows up in two ways. A snapshot that moves during a held read is seen as soon as a new event is injected mid-read. A missing or wrong acknowledge on release is seen in the next identification read, as a transmit-empty code that fails to clear or one that clears when it should not.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 3;
    localparam int IER_W   = 4;
    localparam int NUM_SRC = 5;

    // pending vector bit positions
    localparam int S_LINE  = 4;
    localparam int S_RXAV  = 3;
    localparam int S_TMO   = 2;
    localparam int S_TXE   = 1;
    localparam int S_MODEM = 0;

    // enable register bit positions
    localparam int E_RX    = 0;
    localparam int E_TXE   = 1;
    localparam int E_LINE  = 2;
    localparam int E_MODEM = 3;

    // register offsets
    localparam logic [ADDR_W-1:0] A_DATA  = 3'd0;
    localparam logic [ADDR_W-1:0] A_IEN   = 3'd1;
    localparam logic [ADDR_W-1:0] A_IDENT = 3'd2;
    localparam logic [ADDR_W-1:0] A_LSTAT = 3'd5;
    localparam logic [ADDR_W-1:0] A_MSTAT = 3'd6;

    // identification codes, bits 3:0
    localparam logic [3:0] C_LINE  = 4'b0110;
    localparam logic [3:0] C_RXAV  = 4'b0100;
    localparam logic [3:0] C_TMO   = 4'b1100;
    localparam logic [3:0] C_TXE   = 4'b0010;
    localparam logic [3:0] C_MODEM = 4'b0000;
    localparam logic [3:0] C_NONE  = 4'b0001;

    typedef enum logic [0:0] {
        ST_IDLE   = 1'b0,
        ST_FROZEN = 1'b1
    } snap_state_e;

endpackage

// File: rtl/uirq_enable_reg.sv
module uirq_enable_reg
    import uirq_pkg::*;
#(
    parameter int W  = IER_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [W-1:0]  ier_o
);

    always_ff @(posedge clk) begin
        if (!rst_n)
            ier_o <= '0;
        else if (wr_en)
            ier_o <= wdata[W-1:0];
    end

    // R2: enable bits only change on a write
    a_r2_ier_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ier_o));

endmodule

// File: rtl/uirq_pending.sv
module uirq_pending #(
    parameter int N = uirq_pkg::NUM_SRC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);

    for (genvar g = 0; g < N; g++) begin : g_src
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_o[g] <= 1'b0;
            else if (set_i[g])
                pend_o[g] <= 1'b1;
            else if (clr_i[g])
                pend_o[g] <= 1'b0;
        end
    end

    // R12: an event seen at an edge is pending right after it, even with a clear
    a_r12_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        |set_i |=> ((pend_o & $past(set_i)) == $past(set_i)));

endmodule

// File: rtl/uirq_prio_enc.sv
module uirq_prio_enc
    import uirq_pkg::*;
(
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [IER_W-1:0]   ier_i,
    input  logic               fifo_mode,
    output logic [3:0]         code_o
);

    logic [NUM_SRC-1:0] act;

    always_comb begin
        act          = '0;
        act[S_LINE]  = pend_i[S_LINE]  & ier_i[E_LINE];
        act[S_RXAV]  = pend_i[S_RXAV]  & ier_i[E_RX];
        act[S_TMO]   = pend_i[S_TMO]   & ier_i[E_RX] & fifo_mode;
        act[S_TXE]   = pend_i[S_TXE]   & ier_i[E_TXE];
        act[S_MODEM] = pend_i[S_MODEM] & ier_i[E_MODEM];
    end

    always_comb begin
        if (act[S_LINE])       code_o = C_LINE;
        else if (act[S_RXAV])  code_o = C_RXAV;
        else if (act[S_TMO])   code_o = C_TMO;
        else if (act[S_TXE])   code_o = C_TXE;
        else if (act[S_MODEM]) code_o = C_MODEM;
        else                   code_o = C_NONE;
    end

endmodule

// File: rtl/uirq_ctrl.sv
module uirq_ctrl
    import uirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              fifo_mode,
    input  logic              ev_line_err,
    input  logic              ev_rx_avail,
    input  logic              ev_rx_timeout,
    input  logic              ev_tx_empty,
    input  logic              ev_modem_chg,
    output logic              irq
);

    snap_state_e        state_q, state_d;
    logic [IER_W-1:0]   ier;
    logic [NUM_SRC-1:0] pend, set_v, clr_v;
    logic [3:0]         live_code, snap_q;
    logic               id_rd, snap_load, release_ack;

    assign id_rd = reg_rd && (reg_addr == A_IDENT);

    uirq_enable_reg #(.W(IER_W), .DW(DATA_W)) u_ien (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (reg_wr && (reg_addr == A_IEN)),
        .wdata (reg_wdata),
        .ier_o (ier)
    );

    always_comb begin
        set_v          = '0;
        set_v[S_LINE]  = ev_line_err;
        set_v[S_RXAV]  = ev_rx_avail;
        set_v[S_TMO]   = ev_rx_timeout & fifo_mode;
        set_v[S_TXE]   = ev_tx_empty;
        set_v[S_MODEM] = ev_modem_chg;

        clr_v          = '0;
        clr_v[S_LINE]  = reg_rd && (reg_addr == A_LSTAT);
        clr_v[S_RXAV]  = reg_rd && (reg_addr == A_DATA);
        clr_v[S_TMO]   = reg_rd && (reg_addr == A_DATA);
        clr_v[S_TXE]   = (reg_wr && (reg_addr == A_DATA)) || release_ack;
        clr_v[S_MODEM] = reg_rd && (reg_addr == A_MSTAT);
    end

    uirq_pending #(.N(NUM_SRC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_v),
        .clr_i  (clr_v),
        .pend_o (pend)
    );

    uirq_prio_enc u_enc (
        .pend_i    (pend),
        .ier_i     (ier),
        .fifo_mode (fifo_mode),
        .code_o    (live_code)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state and per-state outputs
    always_comb begin
        state_d     = state_q;
        snap_load   = 1'b0;
        release_ack = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (id_rd)
                    state_d = ST_FROZEN;   // capture
                else
                    snap_load = 1'b1;
            end
            ST_FROZEN: begin
                if (!id_rd) begin
                    state_d     = ST_IDLE; // release
                    release_ack = (snap_q == C_TXE);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            snap_q <= C_NONE;
        else if (snap_load)
            snap_q <= live_code;
    end

    assign irq = ~snap_q[0];

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == A_IEN)
            reg_rdata[IER_W-1:0] = ier;
        else if (reg_addr == A_IDENT)
            reg_rdata = {{2{fifo_mode}}, 2'b00, snap_q};
    end

    // R8: identification byte steady across a held read
    a_r8_frozen_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (id_rd && $past(id_rd) && $stable(fifo_mode)) |-> $stable(reg_rdata));

    // R2: upper enable bits read zero
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == A_IEN) |-> (reg_rdata[7:4] == 4'h0));

    // R6: time-out flag only appears together with bit 2
    a_r6_tmo_flag: assert property (@(posedge clk) disable iff (!rst_n)
        snap_q[3] |-> (snap_q[2:0] == 3'b100));

    // R3: nothing pending while tracking means no request one edge later
    a_r3_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && live_code == C_NONE && !id_rd) |=> !irq);

endmodule

// File: tb/test_uirq_ctrl.sv
module test_uirq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_rd = 1'b0, reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       fifo_mode = 1'b0;
    logic       ev_line_err = 1'b0, ev_rx_avail = 1'b0, ev_rx_timeout = 1'b0;
    logic       ev_tx_empty = 1'b0, ev_modem_chg = 1'b0;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    uirq_ctrl i_uirq_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fifo_mode(fifo_mode), .ev_line_err(ev_line_err),
        .ev_rx_avail(ev_rx_avail), .ev_rx_timeout(ev_rx_timeout),
        .ev_tx_empty(ev_tx_empty), .ev_modem_chg(ev_modem_chg), .irq(irq)
    );

    // {req, fifo, ier[3:0], events {line,rxav,tmo,txe,modem}, expected id}
    localparam int NV = 13;
    localparam logic [21:0] VEC [NV] = '{
        {4'd3, 1'b0, 4'hF, 5'b10000, 8'h06},   // R3 line error
        {4'd3, 1'b0, 4'hF, 5'b01000, 8'h04},   // R3 data available
        {4'd3, 1'b0, 4'hF, 5'b00010, 8'h02},   // R3 transmit empty
        {4'd3, 1'b0, 4'hF, 5'b00001, 8'h00},   // R3 modem change
        {4'd4, 1'b0, 4'hF, 5'b11111, 8'h06},   // R4 all pending
        {4'd4, 1'b0, 4'hF, 5'b01011, 8'h04},   // R4
        {4'd4, 1'b0, 4'hF, 5'b00011, 8'h02},   // R4
        {4'd5, 1'b0, 4'h0, 5'b11111, 8'h01},   // R5 all masked
        {4'd6, 1'b0, 4'hF, 5'b00100, 8'h01},   // R6 time-out ignored
        {4'd6, 1'b1, 4'hF, 5'b00100, 8'hCC},   // R6 R7 time-out in FIFO mode
        {4'd6, 1'b1, 4'hF, 5'b01100, 8'hC4},   // R6 data ahead of time-out
        {4'd7, 1'b1, 4'hA, 5'b11111, 8'hC2},   // R7 R5 line and data masked
        {4'd5, 1'b0, 4'h8, 5'b11111, 8'h00}    // R5 only modem enabled
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_strobe(input logic [2:0] a);
        reg_addr = a; reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rd_val(input logic [2:0] a, output logic [7:0] v);
        reg_addr = a; reg_rd = 1'b1;
        #2 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic pulse(input logic [4:0] e);
        {ev_line_err, ev_rx_avail, ev_rx_timeout, ev_tx_empty, ev_modem_chg} = e;
        @(negedge clk);
        {ev_line_err, ev_rx_avail, ev_rx_timeout, ev_tx_empty, ev_modem_chg} = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] v;
        @(negedge clk);
        do_reset();

        // R1 reset state
        rd_val(3'd2, v); check("R1 ident", v, 8'h01);
        check("R1 irq", {7'd0, irq}, 8'h00);
        rd_val(3'd1, v); check("R1 ier", v, 8'h00);

        // R2 upper enable bits
        wr_reg(3'd1, 8'hFF);
        rd_val(3'd1, v); check("R2 ier", v, 8'h0F);

        // vector table
        for (int i = 0; i < NV; i++) begin
            do_reset();
            fifo_mode = VEC[i][17];
            wr_reg(3'd1, {4'h0, VEC[i][16:13]});
            pulse(VEC[i][12:8]);
            settle();
            rd_val(3'd2, v);
            check($sformatf("R%0d vector %0d", VEC[i][21:18], i), v, VEC[i][7:0]);
            check($sformatf("R3 irq vector %0d", i), {7'd0, irq}, {7'd0, ~VEC[i][0]});
        end
        fifo_mode = 1'b0;

        // R12 event latency
        do_reset();
        wr_reg(3'd1, 8'h0F);
        pulse(5'b01000);
        #2 check("R12 irq before", {7'd0, irq}, 8'h00);
        @(negedge clk);
        #2 check("R12 irq after", {7'd0, irq}, 8'h01);
        // R11 receive read clears data available
        rd_strobe(3'd0); settle();
        rd_val(3'd2, v); check("R11 cleared", v, 8'h01);

        // R9 cleared by the read that reported it
        pulse(5'b00010); settle();
        rd_val(3'd2, v); check("R9 reported", v, 8'h02);
        settle();
        rd_val(3'd2, v); check("R9 ack by ident read", v, 8'h01);
        // R9 cleared by transmit write
        pulse(5'b00010); settle();
        wr_reg(3'd0, 8'h55); settle();
        rd_val(3'd2, v); check("R9 ack by write", v, 8'h01);
        // R9 not cleared when another source was reported
        pulse(5'b10010); settle();
        rd_val(3'd2, v); check("R9 line first", v, 8'h06);
        settle();
        rd_strobe(3'd5); settle();   // R10 line status read
        rd_val(3'd2, v); check("R9 txe still pending", v, 8'h02);
        settle();
        rd_val(3'd2, v); check("R9 txe acked", v, 8'h01);

        // R10 modem read
        pulse(5'b00001); settle();
        rd_val(3'd2, v); check("R10 modem", v, 8'h00);
        rd_strobe(3'd6); settle();
        rd_val(3'd2, v); check("R10 modem cleared", v, 8'h01);

        // R8 frozen during a held read
        pulse(5'b00010); settle();
        reg_addr = 3'd2; reg_rd = 1'b1;
        #2 check("R8 first cycle", reg_rdata, 8'h02);
        @(negedge clk); ev_line_err = 1'b1;
        @(negedge clk); ev_line_err = 1'b0;
        @(negedge clk);
        #2 check("R8 held value", reg_rdata, 8'h02);
        check("R8 held irq", {7'd0, irq}, 8'h01);
        reg_rd = 1'b0;
        @(negedge clk);
        settle();
        rd_val(3'd2, v); check("R8 after release", v, 8'h06);
        settle();
        rd_strobe(3'd5); settle();
        rd_val(3'd2, v); check("R9 txe acked on release", v, 8'h01);

        // R5 pending while masked, reported once enabled
        wr_reg(3'd1, 8'h00);
        pulse(5'b01000); settle();
        rd_val(3'd2, v); check("R5 masked", v, 8'h01);
        wr_reg(3'd1, 8'h01); settle();
        rd_val(3'd2, v); check("R5 enabled", v, 8'h04);

        summary();
        $finish;
    end

endmodule